// File: doc/BRIEF.md
# Multi-Width Serial Receive Datapath

The block takes a serial bit stream on one data pin, one bit per clock, and turns it into words that a host reads from two 16-bit data registers. A frame starts when the frame-sync input is high together with the first data bit. A frame carries one word, or two words when two-phase mode is on. Each phase has its own word length: 8, 12, 16, 20, 24 or 32 bits. Bits arrive most significant first.

A word moves through three stages. It is first assembled in a shift stage, then held in a buffer, then copied into the host registers. The copy into the host registers waits until those registers are empty. On that copy an 8-bit word can be expanded from mu-law or A-law into a left-justified 16-bit linear sample. Any other word is justified inside the host registers and its unused bits are filled. Words of 16 bits or fewer use only the low register. Longer words also use the high register, which holds the upper bits.

The host sees a ready flag. Reading the low register clears it. An overrun flag reports any word that was lost because the buffer was still occupied.

Top module: `ser_rx_path`

## Requirements
- R1: After reset, data_lo_o, data_hi_o, ready_o and overrun_o are all zero.
- R2: The word-length codes select these lengths: 0 is 8 bits, 1 is 12, 2 is 16, 3 is 20, 4 is 24, 5 is 32. Codes 6 and 7 select 8 bits. Bits are taken most significant first, one per clock.
- R3: A frame starts on a clock where fsync_i is high and the block is idle, and that clock's bit is the first bit of the frame. With dual_phase_i high, the phase-1 word, of length len_ph1_i, follows with no gap. fsync_i has no effect while a frame is in progress.
- R4: A word of 16 bits or fewer is placed in data_lo_o, and data_hi_o is written with zero.
- R5: For a word longer than 16 bits, data_hi_o holds bits 31..16 of the justified 32-bit result and data_lo_o holds bits 15..0.
- R6: With just_mode_i equal to 00 or 11, the word is right-justified and zero-filled.
- R7: With just_mode_i equal to 01, the word is right-justified and its top received bit is copied into all upper bits of the 16-bit result (short words) or the 32-bit result (long words).
- R8: With just_mode_i equal to 10, the word is left-justified in 16 bits (short words) or 32 bits (long words), and the low bits are zero.
- R9: If comp_mode_i is 10 and the word is 8 bits, data_lo_o gets the mu-law expansion: the code inverted gives sign, exponent e and mantissa m, and the magnitude is ((8m+132)<<e)-132. If comp_mode_i is 11 and the word is 8 bits, data_lo_o gets the A-law expansion: the code XOR 0x55 gives sign (1 means positive), e and m, and the magnitude is 16m+8 when e is 0, else (16m+264)<<(e-1). In both cases data_hi_o is 0. Companding has no effect on other lengths, and comp_mode_i 01 means no companding.
- R10: The clock that samples a word's last bit loads the buffer. The next clock copies the word into the host registers and sets ready_o, if ready_o was low. While ready_o is high, the host registers are held and a buffered word waits.
- R11: A rising clock with rd_lo_i high clears ready_o, and a waiting word is copied on the following clock. If a word completes while the buffer holds a word that is not being copied, overrun_o is set and the new word is dropped. rd_lo_i clears overrun_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial data bit |
| fsync_i | input | 1 | Frame sync, high with the first bit of a frame |
| len_ph0_i | input | 3 | Word-length code for phase 0 |
| len_ph1_i | input | 3 | Word-length code for phase 1 |
| dual_phase_i | input | 1 | Frame has two phases |
| comp_mode_i | input | 2 | Companding mode |
| just_mode_i | input | 2 | Justification and fill mode |
| rd_lo_i | input | 1 | Host read of the low data register |
| data_lo_o | output | 16 | Low host data register |
| data_hi_o | output | 16 | High host data register |
| ready_o | output | 1 | Host registers hold an unread word |
| overrun_o | output | 1 | A received word was dropped |

## Verification
The buffer is loaded on the rising edge that samples a word's last bit. The host registers and ready_o change one edge later, so a word's value appears two edges after its last bit is driven. A read clears ready_o on the edge where rd_lo_i is sampled, and a waiting word lands one edge after that. overrun_o rises on the edge of the dropped word's last bit. The bench drives inputs on falling edges and samples on the falling edge that follows the due edge. It also checks that ready_o is still low one edge before the copy, so an extra or missing stage shows up as a failure.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int CNT_W  = $clog2(WORD_W) + 1;

  typedef enum logic [1:0] {
    JUST_RZ  = 2'b00,
    JUST_RS  = 2'b01,
    JUST_LZ  = 2'b10,
    JUST_RSV = 2'b11
  } just_e;

  function automatic logic [CNT_W-1:0] len_bits(input logic [2:0] code);
    case (code)
      3'd1:    len_bits = CNT_W'(12);
      3'd2:    len_bits = CNT_W'(16);
      3'd3:    len_bits = CNT_W'(20);
      3'd4:    len_bits = CNT_W'(24);
      3'd5:    len_bits = CNT_W'(32);
      default: len_bits = CNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/rx_shift.sv
module rx_shift
  import ser_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              fsync_i,
  input  logic [2:0]        len_ph0_i,
  input  logic [2:0]        len_ph1_i,
  input  logic              dual_phase_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  wlen_o
);
  logic              active_q, phase_q;
  logic [CNT_W-1:0]  cnt_q, cur_len;
  logic [WORD_W-2:0] sh_q;

  assign cur_len = phase_q ? len_bits(len_ph1_i) : len_bits(len_ph0_i);
  assign word_o  = {sh_q, sdata_i};
  assign wlen_o  = cur_len;
  assign done_o  = active_q && (cnt_q == cur_len - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else if (!active_q) begin
      if (fsync_i) begin
        active_q <= 1'b1;
        phase_q  <= 1'b0;
        cnt_q    <= CNT_W'(1);
        sh_q     <= (WORD_W-1)'(sdata_i);
      end
    end else if (done_o) begin
      cnt_q <= '0;
      sh_q  <= '0;  // next word starts from clean upper bits
      if (!phase_q && dual_phase_i) phase_q <= 1'b1;
      else active_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      sh_q  <= word_o[WORD_W-2:0];
    end
  end

  a_r3_idle_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> cnt_q == '0);
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> cnt_q < cur_len);
endmodule

// File: rtl/rx_expand.sv
module rx_expand
  import ser_rx_pkg::*;
(
  input  logic [7:0]        code_i,
  input  logic              alaw_i,
  output logic [HALF_W-1:0] lin_o
);
  logic [7:0]        u, a;
  logic [HALF_W-1:0] mu_t, mu_mag, al_base, al_mag, mu_lin, al_lin;

  assign u       = ~code_i;
  assign a       = code_i ^ 8'h55;
  assign mu_t    = ({8'b0, u[3:0], 3'b0} + 16'h0084) << u[6:4];
  assign mu_mag  = mu_t - 16'd132;
  assign mu_lin  = u[7] ? (16'd0 - mu_mag) : mu_mag;
  assign al_base = {8'b0, a[3:0], 4'b0};
  assign al_mag  = (a[6:4] == 3'd0) ? al_base + 16'd8
                 : (al_base + 16'h0108) << (a[6:4] - 3'd1);
  assign al_lin  = a[7] ? al_mag : (16'd0 - al_mag);
  assign lin_o   = alaw_i ? al_lin : mu_lin;
endmodule

// File: rtl/rx_fmt.sv
module rx_fmt
  import ser_rx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  wlen_i,
  input  logic [1:0]        comp_i,
  input  logic [1:0]        just_i,
  output logic [HALF_W-1:0] lo_o,
  output logic [HALF_W-1:0] hi_o
);
  logic [HALF_W-1:0] lin;
  logic [WORD_W-1:0] mask, sx, lz, res;
  logic [CNT_W-1:0]  lshift;
  logic              is_long, expand;

  rx_expand u_expand (.code_i(word_i[7:0]), .alaw_i(comp_i[0]), .lin_o(lin));

  assign is_long = wlen_i > CNT_W'(HALF_W);
  assign expand  = comp_i[1] && (wlen_i == CNT_W'(8));
  assign mask    = (wlen_i >= CNT_W'(WORD_W)) ? '1
                 : ((WORD_W'(1) << wlen_i) - WORD_W'(1));
  assign lshift  = CNT_W'(WORD_W) - wlen_i;
  assign sx      = word_i[wlen_i - CNT_W'(1)] ? (word_i | ~mask) : (word_i & mask);
  assign lz      = word_i << lshift;

  always_comb begin
    unique case (just_e'(just_i))
      JUST_RS: res = sx;
      JUST_LZ: res = is_long ? lz : {16'b0, lz[WORD_W-1:HALF_W]};
      default: res = word_i & mask;
    endcase
    if (expand) begin
      lo_o = lin;
      hi_o = '0;
    end else begin
      lo_o = res[HALF_W-1:0];
      hi_o = is_long ? res[WORD_W-1:HALF_W] : '0;
    end
  end
endmodule

// File: rtl/ser_rx_path.sv
module ser_rx_path
  import ser_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sdata_i,
  input  logic        fsync_i,
  input  logic [2:0]  len_ph0_i,
  input  logic [2:0]  len_ph1_i,
  input  logic        dual_phase_i,
  input  logic [1:0]  comp_mode_i,
  input  logic [1:0]  just_mode_i,
  input  logic        rd_lo_i,
  output logic [15:0] data_lo_o,
  output logic [15:0] data_hi_o,
  output logic        ready_o,
  output logic        overrun_o
);
  logic              done;
  logic [WORD_W-1:0] word, buf_q;
  logic [CNT_W-1:0]  wlen, blen_q;
  logic              buf_full_q, ready_q, ovr_q, cp, take, ovr_set;
  logic [HALF_W-1:0] f_lo, f_hi, lo_q, hi_q;

  rx_shift u_shift (
    .clk_i, .rst_ni, .sdata_i, .fsync_i, .len_ph0_i, .len_ph1_i, .dual_phase_i,
    .done_o(done), .word_o(word), .wlen_o(wlen)
  );

  rx_fmt u_fmt (
    .word_i(buf_q), .wlen_i(blen_q), .comp_i(comp_mode_i), .just_i(just_mode_i),
    .lo_o(f_lo), .hi_o(f_hi)
  );

  assign cp      = buf_full_q && !ready_q;
  assign take    = done && (!buf_full_q || cp);
  assign ovr_set = done && buf_full_q && !cp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q      <= '0;
      blen_q     <= CNT_W'(8);
      buf_full_q <= 1'b0;
    end else if (take) begin
      buf_q      <= word;
      blen_q     <= wlen;
      buf_full_q <= 1'b1;
    end else if (cp) begin
      buf_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      hi_q    <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (cp) begin
        lo_q    <= f_lo;
        hi_q    <= f_hi;
        ready_q <= 1'b1;
      end else if (rd_lo_i) begin
        ready_q <= 1'b0;
      end
      if (ovr_set)      ovr_q <= 1'b1;
      else if (rd_lo_i) ovr_q <= 1'b0;
    end
  end

  assign data_lo_o = lo_q;
  assign data_hi_o = hi_q;
  assign ready_o   = ready_q;
  assign overrun_o = ovr_q;

  a_r11_ready_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && rd_lo_i |=> !ready_o);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !rd_lo_i |=> ready_o && $stable(data_lo_o) && $stable(data_hi_o));
  a_r4_short_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp && blen_q <= CNT_W'(HALF_W) |=> data_hi_o == '0);
  a_r11_ovr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && buf_full_q && ready_o |=> overrun_o);
  a_r10_copy_sets_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_full_q && !ready_o |=> ready_o);
endmodule

// File: tb/tb_ser_rx_path.sv
module tb_ser_rx_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdata = 1'b0, fsync = 1'b0, dual = 1'b0, rd = 1'b0;
  logic [2:0]  len0 = 3'd0, len1 = 3'd0;
  logic [1:0]  comp = 2'b00, just = 2'b00;
  logic [15:0] lo, hi;
  logic        ready, ovr;
  int          checks = 0, fails = 0;
  bit          ended = 1'b0;

  always #2 clk = ~clk;

  ser_rx_path dut (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .fsync_i(fsync),
    .len_ph0_i(len0), .len_ph1_i(len1), .dual_phase_i(dual),
    .comp_mode_i(comp), .just_mode_i(just), .rd_lo_i(rd),
    .data_lo_o(lo), .data_hi_o(hi), .ready_o(ready), .overrun_o(ovr)
  );

  function automatic int nbits(input int code);
    case (code)
      1: return 12; 2: return 16; 3: return 20; 4: return 24; 5: return 32;
      default: return 8;
    endcase
  endfunction

  function automatic logic [15:0] mu_ref(input int c);
    int u = (~c) & 255, e = (u >> 4) & 7, m = u & 15;
    int mag = (33 + 2 * m) * 4 * (1 << e) - 132;
    return 16'((u >= 128) ? -mag : mag);
  endfunction

  function automatic logic [15:0] al_ref(input int c);
    int a = c ^ 85, e = (a >> 4) & 7, m = a & 15, mag;
    mag = (e == 0) ? 16 * m + 8 : (2 * m + 33) * 8 * (1 << (e - 1));
    return 16'((a >= 128) ? mag : -mag);
  endfunction

  // expected {hi,lo}
  function automatic logic [31:0] model(input longint w, input int n, input int cm, input int jm);
    longint v = w & ((64'd1 << n) - 1), r;
    if (cm >= 2 && n == 8) return {16'h0, (cm == 2) ? mu_ref(int'(v)) : al_ref(int'(v))};
    case (jm)
      1: r = v[n-1] ? v - (64'd1 << n) : v;
      2: r = (n <= 16) ? v << (16 - n) : v << (32 - n);
      default: r = v;
    endcase
    return (n <= 16) ? {16'h0, r[15:0]} : r[31:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w, input int n, input bit first, input bit hold);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      sdata = w[i];
      fsync = hold | (first && i == n - 1);
    end
  endtask

  task automatic send_frame(input logic [31:0] w0, input logic [31:0] w1, input bit hold);
    send_word(w0, nbits(len0), 1'b1, hold);
    if (dual) send_word(w1, nbits(len1), 1'b0, hold);
    @(negedge clk);
    sdata = 1'b0;
    fsync = 1'b0;
  endtask

  task automatic read_lo();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  // send one word, check latency and value, then read it
  task automatic one_word(input string req, input int code, input logic [31:0] w);
    len0 = 3'(code);
    send_frame(w, 32'h0, 1'b0);
    chk({req, " R10 not yet ready"}, 32'(ready), 32'd0);
    @(negedge clk);
    chk({req, " R10 ready"}, 32'(ready), 32'd1);
    chk(req, {hi, lo}, model(longint'(w), nbits(code), int'(comp), int'(just)));
    read_lo();
    chk({req, " R11 ready cleared"}, 32'(ready), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 lo", 32'(lo), 32'd0);
    chk("R1 hi", 32'(hi), 32'd0);
    chk("R1 flags", {30'd0, ready, ovr}, 32'd0);
  endtask

  task automatic t_widths();
    comp = 2'b00; just = 2'b00; dual = 1'b0;
    one_word("R2 R4 R6 len8", 0, 32'h000000A5);
    one_word("R2 R4 R6 len12", 1, 32'h00000ABC);
    one_word("R2 R4 R6 len16", 2, 32'h0000C3F1);
    one_word("R2 R5 R6 len20", 3, 32'h0009ABCD);
    one_word("R2 R5 R6 len24", 4, 32'h00F0E1D2);
    one_word("R2 R5 R6 len32", 5, 32'hDEADBEEF);
    one_word("R2 code7 as 8", 7, 32'h0000005C);
    just = 2'b11;
    one_word("R6 reserved just", 1, 32'h00000F81);
  endtask

  task automatic t_just();
    comp = 2'b00;
    just = 2'b01;
    one_word("R7 sign 12 neg", 1, 32'h00000A31);
    one_word("R7 sign 12 pos", 1, 32'h00000531);
    one_word("R7 sign 24 neg", 4, 32'h00800001);
    just = 2'b10;
    one_word("R8 left 12", 1, 32'h00000ABC);
    one_word("R8 left 20", 3, 32'h000FEDCB);
    one_word("R8 left 8", 0, 32'h00000081);
  endtask

  task automatic t_compand();
    just = 2'b00;
    comp = 2'b10;
    one_word("R9 mu 00", 0, 32'h00);
    one_word("R9 mu FF", 0, 32'hFF);
    one_word("R9 mu 9A", 0, 32'h9A);
    comp = 2'b11;
    one_word("R9 A D5", 0, 32'hD5);
    one_word("R9 A 55", 0, 32'h55);
    one_word("R9 A AA", 0, 32'hAA);
    comp = 2'b10;
    one_word("R9 no expand len16", 2, 32'h0000809A);
    comp = 2'b01;
    one_word("R9 mode 01 plain", 0, 32'h0000009A);
    comp = 2'b00;
  endtask

  task automatic t_two_phase();
    comp = 2'b00; just = 2'b00;
    dual = 1'b1; len0 = 3'd0; len1 = 3'd4;
    send_frame(32'h0000003C, 32'h00ABCDEF, 1'b1);
    @(negedge clk);
    chk("R3 phase0 word", {hi, lo}, 32'h0000003C);
    chk("R10 held while ready", 32'(ready), 32'd1);
    read_lo();
    @(negedge clk);
    chk("R3 phase1 word after read", {hi, lo}, 32'h00ABCDEF);
    chk("R11 waiting word copied", 32'(ready), 32'd1);
    chk("R11 no overrun", 32'(ovr), 32'd0);
    read_lo();
    dual = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 one-phase idle after frame", 32'(ready), 32'd0);
  endtask

  task automatic t_overrun();
    comp = 2'b00; just = 2'b00; dual = 1'b0; len0 = 3'd2;
    send_frame(32'h1111, 32'h0, 1'b0);
    send_frame(32'h2222, 32'h0, 1'b0);
    chk("R11 no overrun yet", 32'(ovr), 32'd0);
    send_frame(32'h3333, 32'h0, 1'b0);
    chk("R11 overrun set", 32'(ovr), 32'd1);
    chk("R10 first word kept", 32'(lo), 32'h1111);
    read_lo();
    chk("R11 overrun cleared by read", 32'(ovr), 32'd0);
    @(negedge clk);
    chk("R11 buffered word next", 32'(lo), 32'h2222);
    read_lo();
    repeat (2) @(negedge clk);
    chk("R11 dropped word absent", 32'(ready), 32'd0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_widths();
    t_just();
    t_compand();
    t_two_phase();
    t_overrun();
    finish_run();
  end
endmodule